// File: doc/BRIEF.md
# Fast Interrupt Request Controller

This block drives the fast interrupt request line of a processor from one external interrupt source. The raw input is synchronised into the clock domain. A source-type setting then decides what counts as a request: a rising edge, a falling edge, a high level or a low level. The active-low request output is gated by an enable flag that software controls.

Software uses a small word-addressed register bus. It programs the trigger type and a stored-only priority value in a mode register, and it loads the handler address into a vector register. It sets the enable flag by writing a 1 to the set-command address and clears it by writing a 1 to the clear-command address. A read-only status word shows the flag.

The core reads the handler address from the acknowledge-vector address. In the two edge modes, that read also clears the latched request, so the request line is released. In the two level modes the read clears nothing, and the line follows the input until the input goes inactive or the source is disabled.

Top module: `fiq_ctrl`

## Requirements
- R1: After reset the enable flag is 0, the mode register reads 0 (trigger type low level, priority 0), the vector register reads 0, no request is latched and `fiq_n` is 1.
- R2: The mode register holds the trigger type in bits [1:0] and a priority value in bits [6:4], and reads back as written. The priority value has no effect on the request output.
- R3: Word address 1 holds the handler address. A read of word address 5 (acknowledge vector) returns the same value.
- R4: Writing a 1 in bit 0 to word address 2 sets the enable flag, and writing a 1 in bit 0 to word address 3 clears it. Writing 0 in bit 0 to either address leaves the flag unchanged. Both addresses read as zero. While the flag is 0, `fiq_n` stays 1.
- R5: Bit 0 of word address 4 reads as the enable flag, and the upper bits read as 0.
- R6: With trigger type 1 (rising edge), a rising edge on `src_in` latches a request, and `fiq_n` goes low and stays low after the input falls again.
- R7: With trigger type 3 (falling edge), only a falling edge on `src_in` latches a request; a rising edge is ignored.
- R8: With trigger type 2 (high level), an enabled `fiq_n` is the inverse of the synchronised input.
- R9: With trigger type 0 (low level), an enabled `fiq_n` equals the synchronised input.
- R10: In an edge mode, a read of word address 5 clears the latched request, and `fiq_n` returns to 1 after the clock edge of that read. In a level mode the read changes nothing.
- R11: Edges that match the trigger type while the source is disabled are still latched. Setting the enable flag afterwards drives `fiq_n` low in the cycle after that write.
- R12: A change on `src_in` reaches `fiq_n` through exactly two synchroniser flops in level mode: it is not visible after one clock edge and is visible after two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, sampled at the clock edge |
| reg_rd | input | 1 | Register read strobe; a read of the acknowledge address takes effect at the clock edge |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| src_in | input | 1 | Asynchronous interrupt source |
| fiq_n | output | 1 | Active-low fast interrupt request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, and that each strobe stays high for exactly one clock edge. The bench drives every bus access from one task that holds a single strobe for one clock period. It changes `src_in` only at the falling clock edge and holds it for at least four cycles, except in the latency check. This lets every edge pass the synchroniser and the edge detector before the next check. Mode changes are made only while the input is low, so the edge detector never sees a false edge when the trigger type switches.

// File: rtl/fiqc_pkg.sv
package fiqc_pkg;

   // Trigger type encoding, held in mode register bits [1:0]
   typedef enum logic [1:0] {
      TRIG_LOW_LVL  = 2'd0,
      TRIG_POS_EDGE = 2'd1,
      TRIG_HIGH_LVL = 2'd2,
      TRIG_NEG_EDGE = 2'd3
   } trig_e;

   // Word offsets of the register map
   localparam int OFS_MODE = 0;
   localparam int OFS_VEC  = 1;
   localparam int OFS_SET  = 2;
   localparam int OFS_CLR  = 3;
   localparam int OFS_STAT = 4;
   localparam int OFS_ACK  = 5;

   localparam int MIN_ADDR_W = 3;

endpackage

// File: rtl/fiqc_sync.sv
module fiqc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain;

   if (STAGES < 2) begin : g_bad_depth
      $error("fiqc_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/fiqc_detect.sv
module fiqc_detect
   import fiqc_pkg::*;
#(
   parameter bit OUT_REG = 1'b0
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  lvl,
   input  trig_e trig,
   input  logic  enable,
   input  logic  ack,
   output logic  pending,
   output logic  fiq_n
);

   logic prev_q;
   logic rise, fall, is_edge, hit, lvl_act, req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise    = lvl & ~prev_q;
   assign fall    = ~lvl & prev_q;
   assign is_edge = (trig == TRIG_POS_EDGE) || (trig == TRIG_NEG_EDGE);
   assign hit     = ((trig == TRIG_POS_EDGE) && rise) ||
                    ((trig == TRIG_NEG_EDGE) && fall);
   assign lvl_act = (trig == TRIG_HIGH_LVL) ? lvl : ~lvl;

   // A new edge wins over an acknowledge in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                pending <= 1'b0;
      else if (hit)              pending <= 1'b1;
      else if (ack && is_edge)   pending <= 1'b0;
   end

   assign req = enable && (is_edge ? pending : lvl_act);

   if (OUT_REG) begin : g_out_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) fiq_n <= 1'b1;
         else        fiq_n <= ~req;
      end
   end else begin : g_out_comb
      assign fiq_n = ~req;
   end

   // R6: a latched request persists until acknowledged in edge mode
   p_pend_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !(ack && is_edge)) |=> pending);

   // R10: an edge-mode acknowledge without a fresh edge clears the request
   p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && is_edge && !hit) |=> !pending);

   // R7: requests are only latched while an edge trigger type is selected
   p_set_edge_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pending) |-> $past(is_edge));

endmodule

// File: rtl/fiqc_regs.sv
module fiqc_regs
   import fiqc_pkg::*;
#(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32,
   parameter int VEC_W   = 32,
   parameter int PRIO_W  = 3,
   parameter int PRIO_SH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output trig_e             trig,
   output logic              enable,
   output logic              ack
);

   localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(OFS_MODE);
   localparam logic [ADDR_W-1:0] AD_VEC  = ADDR_W'(OFS_VEC);
   localparam logic [ADDR_W-1:0] AD_SET  = ADDR_W'(OFS_SET);
   localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(OFS_CLR);
   localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(OFS_STAT);
   localparam logic [ADDR_W-1:0] AD_ACK  = ADDR_W'(OFS_ACK);

   logic [PRIO_W-1:0] prio_q;
   logic [VEC_W-1:0]  vec_q;
   logic [DATA_W-1:0] mode_rd;
   logic              unused_wbits;

   assign unused_wbits = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trig   <= TRIG_LOW_LVL;
         prio_q <= '0;
         vec_q  <= '0;
         enable <= 1'b0;
      end else if (wr) begin
         if (addr == AD_MODE) begin
            trig   <= trig_e'(wdata[1:0]);
            prio_q <= wdata[PRIO_SH +: PRIO_W];
         end
         if (addr == AD_VEC) vec_q <= wdata[VEC_W-1:0];
         if (addr == AD_SET && wdata[0]) enable <= 1'b1;
         if (addr == AD_CLR && wdata[0]) enable <= 1'b0;
      end
   end

   always_comb begin
      mode_rd                    = '0;
      mode_rd[1:0]               = trig;
      mode_rd[PRIO_SH +: PRIO_W] = prio_q;
   end

   always_comb begin
      rdata = '0;
      if (addr == AD_MODE)                       rdata = mode_rd;
      else if (addr == AD_VEC || addr == AD_ACK) rdata = DATA_W'(vec_q);
      else if (addr == AD_STAT)                  rdata[0] = enable;
   end

   assign ack = rd && (addr == AD_ACK);

   // R4: set command raises the flag
   p_set_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AD_SET && wdata[0]) |=> enable);

   // R4: clear command lowers the flag
   p_clr_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && addr == AD_CLR && wdata[0]) |=> !enable);

   // R4: a zero in bit 0 of a command write leaves the flag alone
   p_cmd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (addr == AD_SET || addr == AD_CLR) && !wdata[0]) |=> $stable(enable));

   // R3: a read alone never changes the stored vector
   p_vec_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(vec_q));

endmodule

// File: rtl/fiq_ctrl.sv
module fiq_ctrl
   import fiqc_pkg::*;
#(
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 32,
   parameter int VEC_W       = 32,
   parameter int PRIO_W      = 3,
   parameter int SYNC_STAGES = 2,
   parameter bit OUT_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              src_in,
   output logic              fiq_n
);

   localparam int PRIO_SH = 4;

   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("fiq_ctrl: ADDR_W too small for the register map");
   end
   if (VEC_W > DATA_W || VEC_W < 1) begin : g_bad_vec
      $error("fiq_ctrl: VEC_W must lie in 1..DATA_W");
   end
   if (PRIO_SH + PRIO_W > DATA_W || PRIO_W < 1) begin : g_bad_prio
      $error("fiq_ctrl: priority field does not fit the data word");
   end

   trig_e trig;
   logic  en_q, ack, lvl_s, pend;

   fiqc_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .VEC_W  (VEC_W),
      .PRIO_W (PRIO_W),
      .PRIO_SH(PRIO_SH)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (reg_wr),
      .rd    (reg_rd),
      .addr  (reg_addr),
      .wdata (reg_wdata),
      .rdata (reg_rdata),
      .trig  (trig),
      .enable(en_q),
      .ack   (ack)
   );

   fiqc_sync #(
      .STAGES(SYNC_STAGES)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (src_in),
      .q    (lvl_s)
   );

   fiqc_detect #(
      .OUT_REG(OUT_REG)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl    (lvl_s),
      .trig   (trig),
      .enable (en_q),
      .ack    (ack),
      .pending(pend),
      .fiq_n  (fiq_n)
   );

   // R4 / R11: a disabled source never drives the request line
   p_masked_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q && !$past(en_q)) |-> fiq_n);

   // Bus protocol assumption: one strobe at a time
   p_one_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_rd));

endmodule

// File: tb/tb_fiq_ctrl.sv
module tb_fiq_ctrl;

   localparam logic [2:0] OP_WR  = 3'd0;
   localparam logic [2:0] OP_RD  = 3'd1;
   localparam logic [2:0] OP_PIN = 3'd2;  // data[0]=level, data[15:8]=cycles to wait
   localparam logic [2:0] OP_IRQ = 3'd3;  // data[0]=expected fiq_n

   localparam logic [2:0] A_MODE = 3'd0;
   localparam logic [2:0] A_VEC  = 3'd1;
   localparam logic [2:0] A_SET  = 3'd2;
   localparam logic [2:0] A_CLR  = 3'd3;
   localparam logic [2:0] A_STAT = 3'd4;
   localparam logic [2:0] A_ACK  = 3'd5;

   localparam logic [31:0] HV = 32'h0000_1C40;

   typedef struct packed {
      logic [2:0]  op;
      logic [2:0]  addr;
      logic [31:0] data;
      logic [3:0]  req;
   } row_t;

   localparam int NROWS = 53;
   localparam row_t TBL [NROWS] = '{
      '{OP_RD,  A_STAT, 32'h0,     4'd1},   // R1
      '{OP_RD,  A_MODE, 32'h0,     4'd1},   // R1
      '{OP_RD,  A_VEC,  32'h0,     4'd1},   // R1
      '{OP_IRQ, 3'd0,   32'h1,     4'd1},   // R1
      '{OP_WR,  A_VEC,  HV,        4'd3},   // R3
      '{OP_RD,  A_VEC,  HV,        4'd3},   // R3
      '{OP_RD,  A_ACK,  HV,        4'd3},   // R3
      '{OP_WR,  A_SET,  32'h1,     4'd4},   // R4
      '{OP_RD,  A_STAT, 32'h1,     4'd5},   // R5
      '{OP_RD,  A_SET,  32'h0,     4'd4},   // R4
      '{OP_RD,  A_CLR,  32'h0,     4'd4},   // R4
      '{OP_IRQ, 3'd0,   32'h0,     4'd9},   // R9
      '{OP_PIN, 3'd0,   32'h401,   4'd9},   // R9
      '{OP_IRQ, 3'd0,   32'h1,     4'd9},   // R9
      '{OP_PIN, 3'd0,   32'h400,   4'd9},   // R9
      '{OP_IRQ, 3'd0,   32'h0,     4'd9},   // R9
      '{OP_RD,  A_ACK,  HV,        4'd10},  // R10
      '{OP_IRQ, 3'd0,   32'h0,     4'd10},  // R10 level mode keeps request
      '{OP_WR,  A_CLR,  32'h0,     4'd4},   // R4
      '{OP_RD,  A_STAT, 32'h1,     4'd4},   // R4
      '{OP_WR,  A_CLR,  32'h1,     4'd4},   // R4
      '{OP_RD,  A_STAT, 32'h0,     4'd5},   // R5
      '{OP_IRQ, 3'd0,   32'h1,     4'd4},   // R4
      '{OP_WR,  A_MODE, 32'h72,    4'd2},   // R2
      '{OP_RD,  A_MODE, 32'h72,    4'd2},   // R2
      '{OP_WR,  A_SET,  32'h1,     4'd8},   // R8
      '{OP_IRQ, 3'd0,   32'h1,     4'd8},   // R8
      '{OP_PIN, 3'd0,   32'h401,   4'd8},   // R8
      '{OP_IRQ, 3'd0,   32'h0,     4'd8},   // R8
      '{OP_PIN, 3'd0,   32'h400,   4'd8},   // R8
      '{OP_IRQ, 3'd0,   32'h1,     4'd8},   // R8
      '{OP_WR,  A_MODE, 32'h01,    4'd6},   // R6
      '{OP_PIN, 3'd0,   32'h401,   4'd6},   // R6
      '{OP_IRQ, 3'd0,   32'h0,     4'd6},   // R6
      '{OP_PIN, 3'd0,   32'h400,   4'd6},   // R6
      '{OP_IRQ, 3'd0,   32'h0,     4'd6},   // R6 sticky
      '{OP_RD,  A_ACK,  HV,        4'd10},  // R10
      '{OP_IRQ, 3'd0,   32'h1,     4'd10},  // R10
      '{OP_WR,  A_MODE, 32'h03,    4'd7},   // R7
      '{OP_PIN, 3'd0,   32'h401,   4'd7},   // R7
      '{OP_IRQ, 3'd0,   32'h1,     4'd7},   // R7 rising ignored
      '{OP_PIN, 3'd0,   32'h400,   4'd7},   // R7
      '{OP_IRQ, 3'd0,   32'h0,     4'd7},   // R7
      '{OP_RD,  A_ACK,  HV,        4'd10},  // R10
      '{OP_IRQ, 3'd0,   32'h1,     4'd10},  // R10
      '{OP_WR,  A_CLR,  32'h1,     4'd11},  // R11
      '{OP_PIN, 3'd0,   32'h401,   4'd11},  // R11
      '{OP_PIN, 3'd0,   32'h400,   4'd11},  // R11
      '{OP_IRQ, 3'd0,   32'h1,     4'd11},  // R11
      '{OP_WR,  A_SET,  32'h1,     4'd11},  // R11
      '{OP_IRQ, 3'd0,   32'h0,     4'd11},  // R11
      '{OP_RD,  A_ACK,  HV,        4'd10},  // R10
      '{OP_IRQ, 3'd0,   32'h1,     4'd10}   // R10
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        src_in = 1'b0;
   logic        fiq_n;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fiq_ctrl dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .src_in   (src_in),
      .fiq_n    (fiq_n)
   );

   task automatic check(input bit ok, input int req, input logic [31:0] act,
                        input logic [31:0] exp, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      @(negedge clk);
      reg_wr    = 1'b0;
   endtask

   task automatic do_rd(input logic [2:0] a, input logic [31:0] exp, input int req);
      reg_addr = a;
      reg_rd   = 1'b1;
      #1;
      check(reg_rdata == exp, req, reg_rdata, exp, "read data");
      @(negedge clk);
      reg_rd   = 1'b0;
   endtask

   task automatic set_pin(input logic v, input int cycles);
      src_in = v;
      repeat (cycles) @(negedge clk);
   endtask

   task automatic chk_irq(input logic exp, input int req);
      #1;
      check(fiq_n == exp, req, {31'b0, fiq_n}, {31'b0, exp}, "fiq_n");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NROWS; i++) begin
         case (TBL[i].op)
            OP_WR:   do_wr(TBL[i].addr, TBL[i].data);
            OP_RD:   do_rd(TBL[i].addr, TBL[i].data, int'(TBL[i].req));
            OP_PIN:  set_pin(TBL[i].data[0], int'(TBL[i].data[15:8]));
            default: chk_irq(TBL[i].data[0], int'(TBL[i].req));
         endcase
         if (TBL[i].op == OP_IRQ) @(negedge clk);
      end

      // R2: nonzero priority with falling-edge trigger behaves like priority 0
      do_wr(A_MODE, 32'h73);
      do_rd(A_MODE, 32'h73, 2);
      set_pin(1'b1, 4);
      set_pin(1'b0, 4);
      chk_irq(1'b0, 2);
      @(negedge clk);
      do_rd(A_ACK, HV, 2);
      chk_irq(1'b1, 2);
      @(negedge clk);

      // R12: synchroniser latency in high-level mode
      do_wr(A_MODE, 32'h02);
      set_pin(1'b1, 1);
      chk_irq(1'b1, 12);
      @(negedge clk);
      chk_irq(1'b0, 12);
      set_pin(1'b0, 4);
      chk_irq(1'b1, 12);

      // R1: reset mid-run restores all state
      @(negedge clk);
      set_pin(1'b1, 2);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      do_rd(A_STAT, 32'h0, 1);
      do_rd(A_MODE, 32'h0, 1);
      do_rd(A_VEC, 32'h0, 1);
      chk_irq(1'b1, 1);
      @(negedge clk);

      // R9: low-level mode after reset, enabled
      do_wr(A_SET, 32'h1);
      chk_irq(1'b1, 9);
      @(negedge clk);
      set_pin(1'b0, 4);
      chk_irq(1'b0, 9);

      finish_run();
   end

endmodule